// File: doc/BRIEF.md
# Double-Buffered Percentile Noise Selector

This block takes a stream of 24-bit mean-square energy values, one per accepted input beat, and groups them into sets of 100. The sets go alternately into two banks of one dual-port storage array. As soon as one bank holds its 100th value, a compare-and-swap engine starts ordering that bank from smallest to largest. The next incoming values go into the other bank in the same cycles. When the ordering is complete, the engine reads the 25th-smallest entry of the bank and presents it as a new raw noise level for the channel.

The ordering is a bubble sort. Each adjacent-pair step takes three cycles: load, compare, write back. Each pass visits one entry fewer than the pass before. The engine stops after the first pass that makes no exchange, so a bank that arrives nearly in order is finished in about three hundred cycles. A bank in reverse order takes about fifteen thousand.

A bank can fill while the engine is still busy with the other bank. When that happens, the block raises an overrun flag for one cycle and remembers the new bank. It sorts that bank as soon as the current sort has produced its output.

Top module: `pps_percentile_select`

## Requirements
- R1: While reset is asserted and directly after it is released, `out_valid` and `overrun` are low and `out_data` is zero.
- R2: Accepted values 1 to 100 form the first bank, values 101 to 200 form the second bank, and so on, alternating between the two banks. Each output is computed from exactly the 100 values of one bank. Outputs arrive in the order in which the banks were completed.
- R3: Values are compared as unsigned numbers, and the bank is ordered ascending. The output is the entry at position 24, counting from zero: the 25th smallest value, with duplicates counted individually.
- R4: `out_valid` is a pulse one cycle wide, given once for each completed sort. `out_data` changes only in a cycle where `out_valid` is high.
- R5: Each compare-and-swap step takes three cycles. An exchange writes two adjacent entries in two consecutive cycles. A pass with no exchange ends the sort. For a bank that arrives already in order, `out_valid` is high no more than 3*(100-1)+4 cycles after the edge that accepted the bank's last value.
- R6: An input beat is accepted in every cycle in which `in_valid` is high, including while a sort is running. Writes into the filling bank never disturb the bank being sorted.
- R7: If a bank becomes full while a sort is still running, `overrun` is high for exactly one cycle. The new bank is still sorted afterwards and produces its own output.
- R8: A bank in strictly reverse order, which needs the full set of passes, still produces the correct 25th-smallest value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input beat strobe |
| in_data | input | 24 | Mean-square value for the current beat |
| out_valid | output | 1 | One-cycle pulse marking a new percentile result |
| out_data | output | 24 | 25th-smallest value of the most recently sorted bank |
| overrun | output | 1 | One-cycle pulse when a bank fills while a sort is busy |

## Verification
The checks on writes to the storage array assume that no bank is filled into while that bank is still being sorted. This assumption is lifted once an overrun has been flagged, because from then on new input may land in a bank under sort. The bench keeps to the assumption by feeding each new bank only after the previous result has appeared. The one exception is the overlap scenario: there, a single extra bank is written at full rate during a long sort, and input then stops until both results are out. The alternating-pulse checks assume that banks complete at least two cycles apart, which follows from every bank needing 100 input beats.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [2:0] {
    SRT_IDLE = 3'd0,
    SRT_LOAD = 3'd1,
    SRT_CMP  = 3'd2,
    SRT_SWAP = 3'd3,
    SRT_PICK = 3'd4
  } sort_state_e;

endpackage

// File: rtl/pps_rst_sync.sv
module pps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pps_bank_mem.sv
module pps_bank_mem #(
  parameter int DATA_W = 24,
  parameter int WORDS  = 200,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_wa,
  input  logic [DATA_W-1:0] fill_wd,
  input  logic [ADDR_W-1:0] sort_ra,
  output logic [DATA_W-1:0] sort_rd,
  input  logic              sort_we,
  input  logic [ADDR_W-1:0] sort_wa,
  input  logic [DATA_W-1:0] sort_wd
);

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (fill_we) begin
      mem_q[fill_wa] <= fill_wd;
    end
    if (sort_we) begin
      mem_q[sort_wa] <= sort_wd;
    end
  end

  assign sort_rd = mem_q[sort_ra];

endmodule

// File: rtl/pps_fill_ctrl.sv
module pps_fill_ctrl #(
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              fill_we,
  output logic [ADDR_W-1:0] fill_wa,
  output logic              bank_full,
  output logic              full_bank
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             bank_q, bank_d;
  logic             full_q, full_d;
  logic             fbank_q;
  logic             fbank_en;

  always_comb begin
    ptr_d    = ptr_q;
    bank_d   = bank_q;
    full_d   = 1'b0;
    fbank_en = 1'b0;
    if (in_valid) begin
      if (ptr_q == PTR_W'(DEPTH - 1)) begin
        ptr_d    = '0;
        bank_d   = ~bank_q;
        full_d   = 1'b1;
        fbank_en = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      bank_q  <= 1'b0;
      full_q  <= 1'b0;
      fbank_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      bank_q <= bank_d;
      full_q <= full_d;
      if (fbank_en) begin
        fbank_q <= bank_q;
      end
    end
  end

  assign fill_we   = in_valid;
  assign fill_wa   = ADDR_W'(ptr_q) + (bank_q ? ADDR_W'(DEPTH) : ADDR_W'(0));
  assign bank_full = full_q;
  assign full_bank = fbank_q;

endmodule

// File: rtl/pps_sort_engine.sv
module pps_sort_engine
  import pps_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 100,
  parameter int PCT    = 25,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_bank,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              we,
  output logic [ADDR_W-1:0] wa,
  output logic [DATA_W-1:0] wd,
  output logic              pick_valid,
  output logic [DATA_W-1:0] pick_data,
  output logic              overrun
);

  localparam int IDX_W    = $clog2(DEPTH);
  localparam int PICK_IDX = (PCT * DEPTH) / 100 - 1;

  sort_state_e       state_q, state_d;
  logic              bank_q, bank_d;
  logic [IDX_W-1:0]  j_q, j_d;
  logic [IDX_W-1:0]  lim_q, lim_d;
  logic              swapped_q, swapped_d;
  logic              swp_now_q, swp_now_d;
  logic [DATA_W-1:0] hold_q;
  logic              hold_en;
  logic              pend_q, pend_d;
  logic              pend_bank_q, pend_bank_d;
  logic              outv_q, outv_d;
  logic [DATA_W-1:0] outd_q;
  logic              outd_en;
  logic              ovr_q, ovr_d;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] addr_j;

  assign base   = bank_q ? ADDR_W'(DEPTH) : ADDR_W'(0);
  assign addr_j = base + ADDR_W'(j_q);

  always_comb begin
    state_d     = state_q;
    bank_d      = bank_q;
    j_d         = j_q;
    lim_d       = lim_q;
    swapped_d   = swapped_q;
    swp_now_d   = swp_now_q;
    hold_en     = 1'b0;
    pend_d      = pend_q;
    pend_bank_d = pend_bank_q;
    outv_d      = 1'b0;
    outd_en     = 1'b0;
    ovr_d       = 1'b0;
    we          = 1'b0;
    wa          = addr_j;
    wd          = rd_data;
    rd_addr     = addr_j;

    case (state_q)
      SRT_IDLE: begin
        if (pend_q || start) begin
          state_d   = SRT_LOAD;
          j_d       = '0;
          lim_d     = IDX_W'(DEPTH - 1);
          swapped_d = 1'b0;
          bank_d    = pend_q ? pend_bank_q : start_bank;
          pend_d    = 1'b0;
          if (pend_q && start) begin
            pend_d      = 1'b1;
            pend_bank_d = start_bank;
            ovr_d       = 1'b1;
          end
        end
      end
      SRT_LOAD: begin
        hold_en = 1'b1;
        state_d = SRT_CMP;
      end
      SRT_CMP: begin
        rd_addr   = addr_j + 1'b1;
        swp_now_d = (hold_q > rd_data);
        if (hold_q > rd_data) begin
          we        = 1'b1;
          wa        = addr_j;
          wd        = rd_data;
          swapped_d = 1'b1;
        end
        state_d = SRT_SWAP;
      end
      SRT_SWAP: begin
        if (swp_now_q) begin
          we = 1'b1;
          wa = addr_j + 1'b1;
          wd = hold_q;
        end
        if (j_q == lim_q - 1'b1) begin
          if (!swapped_q || lim_q == IDX_W'(1)) begin
            state_d = SRT_PICK;
          end else begin
            lim_d     = lim_q - 1'b1;
            j_d       = '0;
            swapped_d = 1'b0;
            state_d   = SRT_LOAD;
          end
        end else begin
          j_d     = j_q + 1'b1;
          state_d = SRT_LOAD;
        end
      end
      SRT_PICK: begin
        rd_addr = base + ADDR_W'(PICK_IDX);
        outd_en = 1'b1;
        outv_d  = 1'b1;
        state_d = SRT_IDLE;
      end
      default: state_d = SRT_IDLE;
    endcase

    if (start && state_q != SRT_IDLE) begin
      pend_d      = 1'b1;
      pend_bank_d = start_bank;
      ovr_d       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SRT_IDLE;
      bank_q      <= 1'b0;
      j_q         <= '0;
      lim_q       <= '0;
      swapped_q   <= 1'b0;
      swp_now_q   <= 1'b0;
      hold_q      <= '0;
      pend_q      <= 1'b0;
      pend_bank_q <= 1'b0;
      outv_q      <= 1'b0;
      outd_q      <= '0;
      ovr_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      bank_q      <= bank_d;
      j_q         <= j_d;
      lim_q       <= lim_d;
      swapped_q   <= swapped_d;
      swp_now_q   <= swp_now_d;
      pend_q      <= pend_d;
      pend_bank_q <= pend_bank_d;
      outv_q      <= outv_d;
      ovr_q       <= ovr_d;
      if (hold_en) begin
        hold_q <= rd_data;
      end
      if (outd_en) begin
        outd_q <= rd_data;
      end
    end
  end

  assign pick_valid = outv_q;
  assign pick_data  = outd_q;
  assign overrun    = ovr_q;

endmodule

// File: rtl/pps_percentile_select.sv
module pps_percentile_select #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 100,
  parameter int PCT    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              overrun
);

  localparam int WORDS  = 2 * DEPTH;
  localparam int ADDR_W = $clog2(WORDS);

  logic              rst_n_sync;
  logic              fill_we;
  logic [ADDR_W-1:0] fill_wa;
  logic              bank_full;
  logic              full_bank;
  logic [ADDR_W-1:0] sort_ra;
  logic [DATA_W-1:0] sort_rd;
  logic              sort_we;
  logic [ADDR_W-1:0] sort_wa;
  logic [DATA_W-1:0] sort_wd;

  pps_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pps_fill_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fill (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_valid  (in_valid),
    .fill_we   (fill_we),
    .fill_wa   (fill_wa),
    .bank_full (bank_full),
    .full_bank (full_bank)
  );

  pps_bank_mem #(.DATA_W(DATA_W), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .fill_we (fill_we),
    .fill_wa (fill_wa),
    .fill_wd (in_data),
    .sort_ra (sort_ra),
    .sort_rd (sort_rd),
    .sort_we (sort_we),
    .sort_wa (sort_wa),
    .sort_wd (sort_wd)
  );

  pps_sort_engine #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PCT(PCT), .ADDR_W(ADDR_W)
  ) u_sort (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start      (bank_full),
    .start_bank (full_bank),
    .rd_addr    (sort_ra),
    .rd_data    (sort_rd),
    .we         (sort_we),
    .wa         (sort_wa),
    .wd         (sort_wd),
    .pick_valid (out_valid),
    .pick_data  (out_data),
    .overrun    (overrun)
  );

endmodule

// File: rtl/pps_percentile_select_chk.sv
module pps_percentile_select_chk #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              overrun,
  input logic              fill_we,
  input logic [ADDR_W-1:0] fill_wa,
  input logic              sort_we,
  input logic [ADDR_W-1:0] sort_wa
);

  logic ovr_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_seen_q <= 1'b0;
    end else if (overrun) begin
      ovr_seen_q <= 1'b1;
    end
  end

  assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  assert_swap_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sort_we && $past(sort_we)) |-> (sort_wa == ADDR_W'($past(sort_wa) + 1'b1)));

  assert_swap_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sort_we && $past(sort_we)) |=> !sort_we);

  assert_no_collision_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_seen_q && sort_we && fill_we) |-> (sort_wa != fill_wa));

  assert_ovr_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);

endmodule

bind pps_percentile_select pps_percentile_select_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_data  (out_data),
  .overrun   (overrun),
  .fill_we   (fill_we),
  .fill_wa   (fill_wa),
  .sort_we   (sort_we),
  .sort_wa   (sort_wa)
);

// File: tb/pps_percentile_select_tb_top.sv
module pps_percentile_select_tb_top;

  localparam int DW = 24;
  localparam int N  = 100;

  typedef logic [DW-1:0] bank_t [N];

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          overrun;

  int            n_checks;
  int            n_fails;
  int            n_out;
  int            n_ovr;
  int            n_wide;
  logic          prev_valid;
  logic [DW-1:0] out_log [8];

  pps_percentile_select #(.DATA_W(DW), .DEPTH(N), .PCT(25)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .overrun   (overrun)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    n_out      = 0;
    n_ovr      = 0;
    n_wide     = 0;
    prev_valid = 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (n_out < 8) out_log[n_out] = out_data;
        n_out = n_out + 1;
        if (prev_valid) n_wide = n_wide + 1;
      end
      if (overrun) n_ovr = n_ovr + 1;
      prev_valid = out_valid;
    end
  end

  task automatic report;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_pick(input bank_t v);
    logic [DW-1:0] s [N];
    for (int i = 0; i < N; i++) begin
      logic [DW-1:0] key;
      int p;
      key = v[i];
      p = i;
      while (p > 0 && s[p-1] > key) begin
        s[p] = s[p-1];
        p--;
      end
      s[p] = key;
    end
    return s[24];
  endfunction

  task automatic feed_bank(input bank_t v, input int gap);
    for (int i = 0; i < N; i++) begin
      in_valid = 1'b1;
      in_data  = v[i];
      @(negedge clk);
      if (gap > 0) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic wait_outputs(input int count);
    int t;
    t = 0;
    while (n_out < count && t < 40000) begin
      @(posedge clk);
      t++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {23'd0, out_valid}, 24'd0);
    check("R1 overrun in reset", {23'd0, overrun}, 24'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after release", {23'd0, out_valid}, 24'd0);
    check("R1 data after release", out_data, 24'd0);
  endtask

  task automatic t_ascending;
    bank_t v;
    int cnt;
    for (int i = 0; i < N; i++) v[i] = DW'(1000 + 7 * i);
    feed_bank(v, 0);
    cnt = 0;
    while (!out_valid && cnt < 20000) begin
      @(negedge clk);
      cnt++;
    end
    check("R3 ordered bank A result", out_data, ref_pick(v));
    n_checks++;
    if (cnt > 3 * (N - 1) + 4) begin
      n_fails++;
      $display("FAIL R5 early exit latency: actual %0d expected <= %0d", cnt, 3 * (N - 1) + 4);
    end
    @(negedge clk);
    check("R4 single pulse", {23'd0, out_valid}, 24'd0);
    check("R2 first output count", DW'(n_out), DW'(1));
  endtask

  task automatic t_descending;
    bank_t v;
    for (int i = 0; i < N; i++) v[i] = DW'(50000 - 13 * i);
    feed_bank(v, 0);
    wait_outputs(2);
    check("R8 reverse bank B result", out_log[1], ref_pick(v));
    check("R2 second output count", DW'(n_out), DW'(2));
  endtask

  task automatic t_scrambled;
    bank_t v;
    logic [31:0] x;
    x = 32'h1234_5678;
    for (int i = 0; i < N; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      v[i] = DW'((x >> 8) % 40);
    end
    feed_bank(v, 2);
    wait_outputs(3);
    check("R3 duplicates bank A result", out_log[2], ref_pick(v));
  endtask

  task automatic t_extremes;
    bank_t v;
    for (int i = 0; i < N; i++)
      v[i] = (i % 2 == 0) ? DW'(24'h800000 + i) : DW'(3 * i);
    v[7] = 24'hFFFFFF;
    v[8] = 24'h000000;
    feed_bank(v, 1);
    wait_outputs(4);
    check("R3 unsigned compare bank B", out_log[3], ref_pick(v));
    check("R7 no overrun so far", DW'(n_ovr), DW'(0));
    check("R4 no wide pulses", DW'(n_wide), DW'(0));
  endtask

  task automatic t_overlap;
    bank_t va;
    bank_t vb;
    for (int i = 0; i < N; i++) va[i] = DW'(90000 - 3 * i);
    for (int i = 0; i < N; i++) vb[i] = DW'(((i * 37) % N) * 5 + 11);
    feed_bank(va, 0);
    feed_bank(vb, 0);
    repeat (3) @(negedge clk);
    check("R7 overrun raised once", DW'(n_ovr), DW'(1));
    check("R6 no output yet during sort", DW'(n_out), DW'(4));
    wait_outputs(6);
    check("R6 sorted bank unharmed by fill", out_log[4], ref_pick(va));
    check("R7 overrun bank still sorted", out_log[5], ref_pick(vb));
    check("R4 no wide pulses", DW'(n_wide), DW'(0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    t_reset();
    t_ascending();
    t_descending();
    t_scrambled();
    t_extremes();
    t_overlap();
    report();
  end

endmodule